// File: doc/BRIEF.md
# Burst Serializer with Sync Insertion

This block turns 32-bit words into a serial bit stream for a shared, half-duplex serial line. A host writes words into a one-deep holding register; the block moves each word into a shift register, puts a sync bit (value 1) ahead of every data byte, and sends the resulting 36-bit frame one bit per clock, least significant data bit first. The sync bits give the receiver a known edge before every byte.

The block manages the line on its own. While idle the driver is released (cutoff). The first word enables the driver, a short settle interval passes, and frames follow. If the next word is already held when a frame ends, the next frame follows with no gap. If not, the line stays at the level of the last data bit until a word arrives or a timeout of four frame periods runs out. The timeout restarts with every frame. When it runs out the driver is released again, so a burst ends without any end command. A keep-link input stops the timeout from ending the burst, for a dedicated link.

The controller has four states. IDLE: driver off. SETTLE: driver on, line low, waiting for the settle count. SHIFT: a frame is being sent. GAP: the line is held at the last data bit. The transitions are:
- IDLE to SETTLE when a word is held.
- SETTLE to SHIFT after the settle count, loading the word.
- SHIFT to SHIFT at frame end when a word is held (back-to-back).
- SHIFT to GAP at frame end when no word is held.
- GAP to SHIFT when a word is held.
- GAP to IDLE when the timeout has expired and keep-link is low.

Top module: `burst_serializer`

## Requirements
- R1: Each frame is FRAME_W = 36 bits long. Frame positions 0, 9, 18 and 27 carry a sync bit of value 1.
- R2: Frame position 9k+1+j carries data bit D[8k+j] (k = byte 0..3, j = 0..7). The word is therefore sent least significant bit first, ending with D31.
- R3: After reset and in IDLE: drv_en = 0, busy = 0, ser_out = 0 and wr_ready = 1.
- R4: When a word is accepted while idle, drv_en and busy rise one cycle after the accept edge. ser_out then stays 0 for exactly SETTLE_CYC cycles before the first sync bit of the frame.
- R5: When a frame ends and no word is held, ser_out stays at the level of that frame's D31 for as long as the link stays in GAP.
- R6: If no new frame begins, drv_en and busy fall TIMEOUT_FRAMES*36 cycles after the first bit of the latest frame. With the defaults, a single word keeps drv_en high for SETTLE_CYC+144 cycles.
- R7: While keep_link is 1, the link never leaves GAP on a timeout. If keep_link falls after the timeout has expired, drv_en falls one cycle later.
- R8: A word is accepted on an edge where wr_valid = 1 and wr_ready = 1. wr_ready is 0 from the cycle after an accept until the held word is loaded into the shifter. wr_ready is 1 again in the cycle that drives the first sync bit of that word's frame.
- R9: If a word is held when a frame's last bit is sent, the next frame's sync bit follows in the very next cycle.
- R10: A word accepted while the link is in GAP has its first sync bit driven in the second cycle after the accept edge, with no settle interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Host offers a word |
| wr_data | input | DATA_W | Word offered by the host |
| wr_ready | output | 1 | Holding register is empty |
| keep_link | input | 1 | Stops the timeout from ending the burst |
| ser_out | output | 1 | Serial bit |
| drv_en | output | 1 | Line driver enable; 0 means cutoff |
| busy | output | 1 | Link is in use |

## Verification
The bench builds the block with 32-bit words, 8-bit bytes, a four-frame timeout and SETTLE_CYC = 3. This makes the timeout window 144 cycles, so many complete bursts, gaps and timeouts fit in a short run. Host gaps are drawn at random from 0 to 220 cycles. That range covers:
- back-to-back frames;
- words that arrive while a frame is still shifting;
- words that arrive during GAP;
- words that arrive only after the timeout.

Directed words cover all-zero, all-one and a set D31 held against the following sync bit. The keep-link case holds a gap long after the 144-cycle limit.

// File: rtl/bser_pkg.sv
package bser_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_GAP    = 2'd3
    } bser_state_e;
endpackage

// File: rtl/bser_hold.sv
module bser_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_valid,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic [W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (pop) begin
            full <= 1'b0;
        end else if (push_valid && !full) begin
            full <= 1'b1;
            data <= push_data;
        end
    end

    assert_accept_sets_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !full && !pop) |=> full);
    assert_held_word_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> (full && $stable(data)));
endmodule

// File: rtl/bser_timer.sv
module bser_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic at_limit
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en && !at_limit)
            cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == LAST);

    assert_limit_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (at_limit && !clr) |=> at_limit);
endmodule

// File: rtl/bser_shifter.sv
module bser_shifter #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   load,
    input  logic [DATA_W-1:0]                      data_in,
    input  logic                                   advance,
    output logic                                   ser_bit,
    output logic                                   frame_end,
    output logic                                   sync_slot,
    output logic [$clog2(DATA_W + DATA_W/BYTE_W)-1:0] bit_pos
);
    localparam int NBYTES  = DATA_W / BYTE_W;
    localparam int SLOT_W  = BYTE_W + 1;
    localparam int FRAME_W = DATA_W + NBYTES;
    localparam int PW      = $clog2(FRAME_W);

    logic [FRAME_W-1:0] frame_in;
    logic [FRAME_W-1:0] sync_mask;
    logic [FRAME_W-1:0] shreg;

    for (genvar k = 0; k < NBYTES; k++) begin : g_slot
        assign frame_in[k*SLOT_W]              = 1'b1;
        assign frame_in[k*SLOT_W + 1 +: BYTE_W] = data_in[k*BYTE_W +: BYTE_W];
    end

    for (genvar p = 0; p < FRAME_W; p++) begin : g_mask
        assign sync_mask[p] = ((p % SLOT_W) == 0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_pos <= '0;
        end else if (load) begin
            shreg   <= frame_in;
            bit_pos <= '0;
        end else if (advance) begin
            shreg   <= {shreg[FRAME_W-1], shreg[FRAME_W-1:1]};
            bit_pos <= bit_pos + 1'b1;
        end
    end

    assign ser_bit   = shreg[0];
    assign frame_end = (bit_pos == PW'(FRAME_W - 1));
    assign sync_slot = sync_mask[bit_pos];

    assert_load_starts_with_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ser_bit && bit_pos == '0));
endmodule

// File: rtl/burst_serializer.sv
module burst_serializer
    import bser_pkg::*;
#(
    parameter int DATA_W         = 32,
    parameter int BYTE_W         = 8,
    parameter int TIMEOUT_FRAMES = 4,
    parameter int SETTLE_CYC     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              keep_link,
    output logic              ser_out,
    output logic              drv_en,
    output logic              busy
);
    localparam int NBYTES   = DATA_W / BYTE_W;
    localparam int FRAME_W  = DATA_W + NBYTES;
    localparam int PW       = $clog2(FRAME_W);
    localparam int TO_LIMIT = TIMEOUT_FRAMES * FRAME_W;

    bser_state_e st, st_nxt;

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              load_frame;
    logic              advance;
    logic              shift_bit;
    logic              frame_end;
    logic              sync_slot;
    logic [PW-1:0]     bit_pos;
    logic              settle_done;
    logic              to_done;
    logic              in_settle;
    logic              on_line;

    bser_hold #(.W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .push_valid(wr_valid), .push_data(wr_data),
        .pop(load_frame), .full(hold_full), .data(hold_data)
    );

    bser_shifter #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load(load_frame), .data_in(hold_data), .advance(advance),
        .ser_bit(shift_bit), .frame_end(frame_end),
        .sync_slot(sync_slot), .bit_pos(bit_pos)
    );

    assign in_settle = (st == ST_SETTLE);
    assign on_line   = (st == ST_SHIFT) || (st == ST_GAP);

    bser_timer #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n),
        .clr(!in_settle), .en(in_settle), .at_limit(settle_done)
    );

    bser_timer #(.LIMIT(TO_LIMIT)) u_timeout (
        .clk(clk), .rst_n(rst_n),
        .clr(load_frame), .en(on_line), .at_limit(to_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nxt;
    end

    always_comb begin
        st_nxt     = st;
        load_frame = 1'b0;
        advance    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (hold_full)
                    st_nxt = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    st_nxt     = ST_SHIFT;
                    load_frame = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (frame_end) begin
                    if (hold_full)
                        load_frame = 1'b1;
                    else
                        st_nxt = ST_GAP;
                end else begin
                    advance = 1'b1;
                end
            end
            ST_GAP: begin
                if (hold_full) begin
                    st_nxt     = ST_SHIFT;
                    load_frame = 1'b1;
                end else if (to_done && !keep_link) begin
                    st_nxt = ST_IDLE;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_ready = !hold_full;
        drv_en   = (st != ST_IDLE);
        busy     = (st != ST_IDLE);
        ser_out  = on_line ? shift_bit : 1'b0;
    end

    assert_sync_on_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT && sync_slot) |-> ser_out);
    assert_settle_line_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SETTLE) |-> (drv_en && !ser_out));
    assert_gap_level_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP) |-> $stable(ser_out));
    assert_release_only_on_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> ($past(to_done) && !$past(keep_link)));
    assert_keep_link_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP && keep_link) |=> drv_en);
    assert_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT && frame_end && hold_full) |=> (st == ST_SHIFT && bit_pos == '0 && ser_out));
endmodule

// File: tb/sim_burst_serializer.sv
module sim_burst_serializer;
    localparam int DW  = 32;
    localparam int BW  = 8;
    localparam int TF  = 4;
    localparam int SC  = 3;
    localparam int FW  = DW + DW / BW;
    localparam int TOL = TF * FW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          keep_link = 1'b0;
    logic          wr_ready, ser_out, drv_en, busy;

    always #4 clk = ~clk;

    burst_serializer #(.DATA_W(DW), .BYTE_W(BW), .TIMEOUT_FRAMES(TF), .SETTLE_CYC(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .keep_link(keep_link),
        .ser_out(ser_out), .drv_en(drv_en), .busy(busy)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // expected frame bit: sync 1 at multiples of 9, data LSB first (R1, R2)
    function automatic logic frame_bit(input logic [DW-1:0] w, input int p);
        if (p % (BW + 1) == 0) return 1'b1;
        return w[(p / (BW + 1)) * BW + (p % (BW + 1)) - 1];
    endfunction

    // bench model: 0 idle, 1 settle, 2 shift, 3 gap
    int          m_st, m_pos, m_to, m_sc, m_kind;
    logic        m_full;
    logic [DW-1:0] m_hold, m_word;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pos = 0; m_to = 0; m_sc = 0; m_kind = 0;
            m_full = 0; m_hold = '0; m_word = '0;
        end else begin
            automatic bit push = wr_valid && !m_full;
            automatic logic [DW-1:0] pd = wr_data;
            automatic bit ld = 0;
            automatic int prev = m_st;
            case (m_st)
                0: if (m_full) begin m_st = 1; m_sc = 0; end
                1: if (m_sc == SC - 1) ld = 1; else m_sc++;
                2: if (m_pos == FW - 1) begin
                       if (m_full) ld = 1; else m_st = 3;
                   end else m_pos++;
                3: if (m_full) ld = 1;
                   else if (m_to == TOL - 1 && !keep_link) m_st = 0;
                default: m_st = 0;
            endcase
            if (ld) begin
                m_kind = prev; m_st = 2; m_word = m_hold;
                m_pos = 0; m_to = 0; m_full = 0;
            end else if ((prev == 2 || prev == 3) && m_to < TOL - 1) begin
                m_to++;
            end
            if (push) begin m_full = 1; m_hold = pd; end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            automatic logic es = (m_st == 2) ? frame_bit(m_word, m_pos) :
                                 (m_st == 3) ? m_word[DW-1] : 1'b0;
            automatic string st_tag;
            if (m_st == 2) begin
                if (m_pos % (BW + 1) == 0)
                    st_tag = (m_kind == 2) ? "R9 sync" : (m_kind == 3) ? "R10 sync" : "R1 sync";
                else
                    st_tag = "R2 data";
            end else if (m_st == 3) st_tag = "R5 gap";
            else if (m_st == 1) st_tag = "R4 settle";
            else st_tag = "R3 idle";
            chk(ser_out === es, {st_tag, " ser_out"}, 32'(ser_out), 32'(es));
            chk(drv_en === (m_st != 0), (m_st == 1) ? "R4 drv_en" : "R6 drv_en", 32'(drv_en), 32'(m_st != 0));
            chk(busy === (m_st != 0), "R6 busy", 32'(busy), 32'(m_st != 0));
            chk(wr_ready === !m_full, "R8 wr_ready", 32'(wr_ready), 32'(!m_full));
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog expired act=%0d exp=done", cyc);
            summary();
        end
    end

    task automatic put(input logic [DW-1:0] d);
        wr_valid = 1'b1;
        wr_data  = d;
        while (1) begin
            automatic logic a = wr_ready;
            @(negedge clk);
            if (a) break;
        end
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (drv_en && n < 2000) begin @(negedge clk); n++; end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        chk(drv_en == 0, "R3 drv_en after reset", 32'(drv_en), 0);
        chk(busy == 0, "R3 busy after reset", 32'(busy), 0);
        chk(ser_out == 0, "R3 ser_out after reset", 32'(ser_out), 0);
        chk(wr_ready == 1, "R3 wr_ready after reset", 32'(wr_ready), 1);

        // single word: R8 ready drop, R6 total drive time
        put(32'hA5C3_0F81);
        chk(wr_ready == 0, "R8 ready low after accept", 32'(wr_ready), 0);
        chk(drv_en == 0, "R4 drv_en not yet", 32'(drv_en), 0);
        begin
            int n = 0;
            @(negedge clk);
            while (drv_en && n < 1000) begin n++; @(negedge clk); end
            chk(n == SC + TOL, "R6 drive duration", n, SC + TOL);
        end
        wait_idle();

        // R10: word written during gap starts without settle
        put(32'h8000_0000);
        repeat (SC + FW + 20) @(negedge clk);
        chk(ser_out == 1, "R5 gap holds D31=1", 32'(ser_out), 1);
        put(32'h0000_0000);
        chk(ser_out == 1, "R10 still in gap", 32'(ser_out), 1);
        @(negedge clk);
        chk(ser_out == 1, "R10 sync bit next cycle", 32'(ser_out), 1);
        @(negedge clk);
        chk(ser_out == 0, "R2 D0 of zero word", 32'(ser_out), 0);
        wait_idle();

        // R9 burst back-to-back, including all-ones
        put(32'hFFFF_FFFF);
        for (int i = 0; i < 16; i++) put($urandom);
        wait_idle();

        // R7 keep link
        put(32'h7FFF_FFFF);
        keep_link = 1'b1;
        repeat (600) @(negedge clk);
        chk(drv_en == 1, "R7 link kept past timeout", 32'(drv_en), 1);
        chk(ser_out == 0, "R5 held D31=0", 32'(ser_out), 0);
        keep_link = 1'b0;
        @(negedge clk);
        chk(drv_en == 0, "R7 release after keep_link falls", 32'(drv_en), 0);
        wait_idle();

        // random traffic
        for (int i = 0; i < 40; i++) begin
            put($urandom);
            repeat ($urandom_range(0, 220)) @(negedge clk);
        end
        wait_idle();
        chk(drv_en == 0, "R6 idle at end", 32'(drv_en), 0);
        summary();
    end
endmodule